// File: doc/BRIEF.md
# Lamp Priority State Controller

This block holds the vehicle lighting mode flags (brake, engine, emergency, left turn, right turn) and decides, once per timing tick, which lamps are lit. The flags are updated from debounced switch levels and from single-cycle press events. An upstream debounce and edge filter supplies both, together with an engine-timeout flag from an idle timer. The lamp outputs follow a fixed priority. Brake wins over everything else. Emergency flashers come next. An engine that is off and timed out comes third and raises a power-down request. Turn signals come last.

Blinking outputs are gated by a flash phase from an internal flasher counter of `FLASH_TICKS` ticks, which is about half a second at the intended tick rate. The counter runs only while a flashing mode is active. Otherwise it is reloaded and the phase is held on the lit half, so a new blink always starts with the lamps lit.

The output mode is a registered state machine. Its states are `MODE_SLEEP` (power-down request), `MODE_BRAKE`, `MODE_EMERG`, `MODE_IDLE`, `MODE_LEFT` and `MODE_RIGHT`. On every tick it moves to the state that the priority picks from the updated flags:
- brake set goes to `MODE_BRAKE`;
- otherwise emergency set goes to `MODE_EMERG`;
- otherwise engine clear goes to `MODE_SLEEP`;
- otherwise left goes to `MODE_LEFT`, right goes to `MODE_RIGHT`, and neither goes to `MODE_IDLE`.

Any state can move to any other state this way. Without a tick it stays where it is.

Top module: `lamp_prio_ctrl`

## Requirements
- R1: On each tick the brake flag takes the value of `brake_in`. While the brake flag is set, both rear lamps are lit steadily, both front lamps are dark and `pd_req` is low, whatever the other flags are.
- R2: A tick with `emg_press` high inverts the emergency flag. A tick without it leaves the flag unchanged, so releasing the button has no effect.
- R3: A tick with `left_press` or `right_press` high sets the matching turn flag.
- R4: A tick with `cancel_evt` high clears both turn flags. This takes precedence over a press in the same tick.
- R5: If a tick would leave both turn flags set, both are cleared instead, and the lamps show the no-turn result.
- R6: With brake clear and emergency set, all four lamps show the flash phase.
- R7: With brake, emergency and engine flags all clear, `pd_req` is 1 and all lamps are dark.
- R8: On a tick, the engine flag is set if `engine_in` is high. It is cleared if `engine_in` is low and `eng_timeout` is high. Otherwise it holds its value.
- R9: With the engine flag set, brake and emergency clear, and exactly one turn flag set, that side's front and rear lamps show the flash phase and the other side is dark. With no turn flag set, all lamps are dark and `pd_req` is 0.
- R10: The flash phase is on (lamps lit) while no flashing mode is active. It turns off on the `FLASH_TICKS`-th consecutive flashing tick, counting the tick that enters flashing as the first. After that it inverts every `FLASH_TICKS` flashing ticks.
- R11: Outputs change only in the cycle after a tick. Between ticks, all lamp outputs and `pd_req` hold their values.
- R12: After reset all flags are clear, `pd_req` is 1 and all lamps are dark.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse that updates flags, state and flasher |
| brake_in | input | 1 | Debounced brake switch level |
| engine_in | input | 1 | Debounced engine-on switch level |
| eng_timeout | input | 1 | Idle timer has expired with the engine off |
| emg_press | input | 1 | Emergency button press event |
| left_press | input | 1 | Left turn press event |
| right_press | input | 1 | Right turn press event |
| cancel_evt | input | 1 | Qualifying turn-cancel event |
| front_left | output | 1 | Front left lamp drive |
| front_right | output | 1 | Front right lamp drive |
| rear_left | output | 1 | Rear left lamp drive |
| rear_right | output | 1 | Rear right lamp drive |
| pd_req | output | 1 | Power-down request |

## Verification
Flags, mode state and flash phase are all registered on the tick edge, and the lamp outputs decode the mode state and phase combinationally. Every result is therefore due exactly one clock after the cycle in which `tick` is high. The bench raises `tick` for one cycle at a falling edge, lowers it at the next falling edge and samples there, one edge after the update. Flash-phase checks count the ticks issued since flashing began, so the off phase is expected on the `FLASH_TICKS`-th such tick. The hold-between-ticks check idles several cycles without a tick before it samples.

// File: rtl/lamp_prio_pkg.sv
package lamp_prio_pkg;

    typedef enum logic [2:0] {
        MODE_SLEEP = 3'd0,
        MODE_BRAKE = 3'd1,
        MODE_EMERG = 3'd2,
        MODE_IDLE  = 3'd3,
        MODE_LEFT  = 3'd4,
        MODE_RIGHT = 3'd5
    } lamp_mode_e;

    typedef struct packed {
        logic brake;
        logic engine;
        logic emerg;
        logic left;
        logic right;
    } mode_flags_t;

endpackage

// File: rtl/lpc_flags.sv
module lpc_flags
    import lamp_prio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        brake_in,
    input  logic        engine_in,
    input  logic        eng_timeout,
    input  logic        emg_press,
    input  logic        left_press,
    input  logic        right_press,
    input  logic        cancel_evt,
    output mode_flags_t flags_q,
    output mode_flags_t flags_d
);

    logic turn_l, turn_r;

    always_comb begin
        flags_d        = flags_q;
        flags_d.brake  = brake_in;
        if (engine_in)
            flags_d.engine = 1'b1;
        else if (eng_timeout)
            flags_d.engine = 1'b0;
        flags_d.emerg  = flags_q.emerg ^ emg_press;
        turn_l = flags_q.left  | left_press;
        turn_r = flags_q.right | right_press;
        if (cancel_evt || (turn_l && turn_r)) begin
            turn_l = 1'b0;
            turn_r = 1'b0;
        end
        flags_d.left   = turn_l;
        flags_d.right  = turn_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flags_q <= '0;
        else if (tick)
            flags_q <= flags_d;
    end

endmodule

// File: rtl/lpc_flasher.sv
module lpc_flasher #(
    parameter int FLASH_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic flashing_d,
    output logic phase_on
);

    localparam int CW = (FLASH_TICKS > 2) ? $clog2(FLASH_TICKS) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(FLASH_TICKS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= RELOAD;
            phase_on <= 1'b1;
        end else if (tick) begin
            if (!flashing_d) begin
                cnt_q    <= RELOAD;
                phase_on <= 1'b1;
            end else if (cnt_q == '0) begin
                cnt_q    <= RELOAD;
                phase_on <= ~phase_on;
            end else begin
                cnt_q    <= cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/lpc_mode_fsm.sv
module lpc_mode_fsm
    import lamp_prio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  mode_flags_t flags_d,
    input  logic        phase_on,
    output logic        front_left,
    output logic        front_right,
    output logic        rear_left,
    output logic        rear_right,
    output logic        pd_req
);

    lamp_mode_e state_q, state_d;

    always_comb begin
        if (flags_d.brake)
            state_d = MODE_BRAKE;
        else if (flags_d.emerg)
            state_d = MODE_EMERG;
        else if (!flags_d.engine)
            state_d = MODE_SLEEP;
        else if (flags_d.left)
            state_d = MODE_LEFT;
        else if (flags_d.right)
            state_d = MODE_RIGHT;
        else
            state_d = MODE_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= MODE_SLEEP;
        else if (tick)
            state_q <= state_d;
    end

    always_comb begin
        front_left  = 1'b0;
        front_right = 1'b0;
        rear_left   = 1'b0;
        rear_right  = 1'b0;
        pd_req      = 1'b0;
        unique case (state_q)
            MODE_SLEEP: pd_req = 1'b1;
            MODE_BRAKE: begin
                rear_left  = 1'b1;
                rear_right = 1'b1;
            end
            MODE_EMERG: begin
                front_left  = phase_on;
                front_right = phase_on;
                rear_left   = phase_on;
                rear_right  = phase_on;
            end
            MODE_LEFT: begin
                front_left = phase_on;
                rear_left  = phase_on;
            end
            MODE_RIGHT: begin
                front_right = phase_on;
                rear_right  = phase_on;
            end
            MODE_IDLE: ;
            default: pd_req = 1'b1;
        endcase
    end

endmodule

// File: rtl/lamp_prio_ctrl.sv
module lamp_prio_ctrl
    import lamp_prio_pkg::*;
#(
    parameter int FLASH_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic brake_in,
    input  logic engine_in,
    input  logic eng_timeout,
    input  logic emg_press,
    input  logic left_press,
    input  logic right_press,
    input  logic cancel_evt,
    output logic front_left,
    output logic front_right,
    output logic rear_left,
    output logic rear_right,
    output logic pd_req
);

    mode_flags_t flags_q, flags_d;
    logic        phase_on;
    logic        flashing_d;

    assign flashing_d = flags_d.emerg | flags_d.left | flags_d.right;

    lpc_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .brake_in   (brake_in),
        .engine_in  (engine_in),
        .eng_timeout(eng_timeout),
        .emg_press  (emg_press),
        .left_press (left_press),
        .right_press(right_press),
        .cancel_evt (cancel_evt),
        .flags_q    (flags_q),
        .flags_d    (flags_d)
    );

    lpc_flasher #(.FLASH_TICKS(FLASH_TICKS)) u_flasher (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .flashing_d(flashing_d),
        .phase_on  (phase_on)
    );

    lpc_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .flags_d    (flags_d),
        .phase_on   (phase_on),
        .front_left (front_left),
        .front_right(front_right),
        .rear_left  (rear_left),
        .rear_right (rear_right),
        .pd_req     (pd_req)
    );

endmodule

// File: rtl/lamp_prio_ctrl_chk.sv
module lamp_prio_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic brake_in,
    input logic emg_press,
    input logic cancel_evt,
    input logic emerg_f,
    input logic left_f,
    input logic right_f,
    input logic front_left,
    input logic front_right,
    input logic rear_left,
    input logic rear_right,
    input logic pd_req
);

    assert_brake_rear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick && brake_in |=> rear_left && rear_right && !front_left && !front_right && !pd_req);

    assert_emg_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick && emg_press |=> emerg_f != $past(emerg_f));

    assert_cancel_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick && cancel_evt |=> !left_f && !right_f);

    assert_no_dual_turn_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(left_f && right_f));

    assert_sleep_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pd_req |-> !(front_left || front_right || rear_left || rear_right));

    assert_hold_between_ticks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable({front_left, front_right, rear_left, rear_right, pd_req}));

endmodule

bind lamp_prio_ctrl lamp_prio_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .brake_in   (brake_in),
    .emg_press  (emg_press),
    .cancel_evt (cancel_evt),
    .emerg_f    (flags_q.emerg),
    .left_f     (flags_q.left),
    .right_f    (flags_q.right),
    .front_left (front_left),
    .front_right(front_right),
    .rear_left  (rear_left),
    .rear_right (rear_right),
    .pd_req     (pd_req)
);

// File: tb/lamp_prio_ctrl_bench.sv
module lamp_prio_ctrl_bench;

    localparam int FT = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic brake_in = 1'b0, engine_in = 1'b0, eng_timeout = 1'b0;
    logic emg_press = 1'b0, left_press = 1'b0, right_press = 1'b0, cancel_evt = 1'b0;
    logic front_left, front_right, rear_left, rear_right, pd_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    lamp_prio_ctrl #(.FLASH_TICKS(FT)) u_lamp_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .brake_in(brake_in), .engine_in(engine_in), .eng_timeout(eng_timeout),
        .emg_press(emg_press), .left_press(left_press), .right_press(right_press),
        .cancel_evt(cancel_evt),
        .front_left(front_left), .front_right(front_right),
        .rear_left(rear_left), .rear_right(rear_right), .pd_req(pd_req)
    );

    // expected order: {pd_req, front_left, front_right, rear_left, rear_right}
    task automatic check_out(input string req, input logic [4:0] exp);
        logic [4:0] act;
        act = {pd_req, front_left, front_right, rear_left, rear_right};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs actual %b expected %b", req, act, exp);
        end
    endtask

    // level inputs are sticky; events last for the single tick cycle
    task automatic do_tick(input logic emg, input logic l, input logic r, input logic can);
        @(negedge clk);
        emg_press = emg; left_press = l; right_press = r; cancel_evt = can;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        emg_press = 1'b0; left_press = 1'b0; right_press = 1'b0; cancel_evt = 1'b0;
    endtask

    task automatic t_reset();
        check_out("R12 reset", 5'b1_0000);
    endtask

    task automatic t_engine_on();
        engine_in = 1'b1;
        do_tick(0, 0, 0, 0);
        check_out("R8 engine on idle R9", 5'b0_0000);
    endtask

    task automatic t_left_blink();
        do_tick(0, 1, 0, 0);
        check_out("R3 R9 left lit", 5'b0_1010);
        for (int i = 2; i < FT; i++) do_tick(0, 0, 0, 0);
        check_out("R10 still lit before period", 5'b0_1010);
        do_tick(0, 0, 0, 0);
        check_out("R10 phase off at period", 5'b0_0000);
        repeat (5) @(negedge clk);
        check_out("R11 hold without tick", 5'b0_0000);
        for (int i = 0; i < FT; i++) do_tick(0, 0, 0, 0);
        check_out("R10 phase back on", 5'b0_1010);
    endtask

    task automatic t_cancel();
        do_tick(0, 0, 0, 1);
        check_out("R4 cancel clears", 5'b0_0000);
        do_tick(0, 1, 0, 1);
        check_out("R4 cancel beats press", 5'b0_0000);
    endtask

    task automatic t_right_then_dual();
        do_tick(0, 0, 1, 0);
        check_out("R3 R9 right lit", 5'b0_0101);
        do_tick(0, 1, 0, 0);
        check_out("R5 dual clears", 5'b0_0000);
        do_tick(0, 0, 0, 0);
        check_out("R5 stays cleared", 5'b0_0000);
    endtask

    task automatic t_emergency_brake();
        do_tick(1, 0, 0, 0);
        check_out("R2 R6 emergency lit", 5'b0_1111);
        brake_in = 1'b1;
        do_tick(0, 0, 0, 0);
        check_out("R1 brake over emergency", 5'b0_0011);
        brake_in = 1'b0;
        do_tick(0, 0, 0, 0);
        check_out("R1 R2 emergency kept after brake", 5'b0_1111);
        do_tick(1, 0, 0, 0);
        check_out("R2 emergency off", 5'b0_0000);
    endtask

    task automatic t_engine_timeout();
        engine_in = 1'b0;
        do_tick(0, 0, 0, 0);
        check_out("R8 engine held without timeout", 5'b0_0000);
        eng_timeout = 1'b1;
        do_tick(0, 0, 0, 0);
        check_out("R7 R8 power-down", 5'b1_0000);
        eng_timeout = 1'b0;
        brake_in = 1'b1;
        do_tick(0, 0, 0, 0);
        check_out("R1 brake over power-down", 5'b0_0011);
        brake_in = 1'b0;
        do_tick(1, 0, 0, 0);
        check_out("R6 emergency over power-down", 5'b0_1111);
        do_tick(1, 0, 0, 0);
        check_out("R7 back to power-down", 5'b1_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_engine_on();
        t_left_blink();
        t_cancel();
        t_right_then_dual();
        t_emergency_brake();
        t_engine_timeout();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule